// File: doc/BRIEF.md
# First-Error Capture and Logging Unit

This unit records diagnostic detail for the first integrity fault seen on the attached buses, or for the first soft error found in an internal data RAM. It then freezes, so that the start of an error chain is not buried under the faults that usually follow it. Error strobes arrive sorted by kind and by the side that saw them: the PCI side as receiver, the PCI side as generator, and the hub side. The unit also sees the live bus values (address, data, byte enables, header) and the context address and data of the request that started the cycle.

Each error kind has its own rule for what is stored. For an address parity fault the intended address is unknown, so the live values are kept. For a data parity fault the unit keeps the live data and the context address. For abort-type cycle errors and RAM soft errors it keeps the context of the originating request. For a split cycle, that context is the original request and not the completion.

Software reads a sticky 16-bit status word and the captured fields. Writing ones to the status word clears those bits, and clearing every bit re-arms the unit. The status and the log survive the functional reset and are cleared only by a separate power-on reset.

Top module: `first_err_log`

## Requirements
- R1: The first qualifying strobe seen while unlocked and out of functional reset is captured at that clock edge, and `lock_o` is high from the following cycle. While locked, further strobes change neither the status word nor any log field.
- R2: Abort strobes (strobe bit 0 of each side port) store the context address and context data. Byte enables and header are stored as zero, and the live address is ignored, so a split completion's address never reaches the log.
- R3: Address parity strobes (strobe bit 1) store the live address, data, byte enables and header.
- R4: Data parity strobes (strobe bit 2) store the context address, the live data and the live byte enables. The header is stored as zero.
- R5: A RAM soft error stores the context address and context data. Byte enables and header are stored as zero.
- R6: Status bit map: bits 0/1/2 are PCI-receiver abort/address parity/data parity; bits 3/4/5 are the same three for the PCI generator; bits 8/9/10 are the same three for the hub side; bit 11 is the RAM soft error. Only the captured source's bit is set.
- R7: Hub-side strobes count only while `hub_is_rcv_i` is 1. Otherwise they are ignored. PCI strobes count in both roles.
- R8: When several qualifying strobes arrive in one cycle, the kind priority is address parity, then data parity, then abort, then RAM. Within a kind the side priority is PCI receiver, then PCI generator, then hub. Status bit 12 (overflow) is set together with the captured bit.
- R9: A write with `clr_we_i` clears the status bits set in `clr_mask_i`. The lock releases at the same edge only if the resulting status word is zero. A partial clear keeps the lock and the log.
- R10: While `rst_n` is low, status, lock and log are kept and strobes are ignored. Clearing writes still act.
- R11: `rst_por_n` low clears the status word, the lock and all log fields.
- R12: Status bits 6, 7, 13, 14 and 15 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous; clears sticky state |
| rst_n | input | 1 | Functional reset, active low; blocks capture, keeps sticky state |
| pci_rcv_err_i | input | 3 | PCI receiver strobes: [0] abort, [1] address parity, [2] data parity |
| pci_gen_err_i | input | 3 | PCI generator strobes, same bit order |
| hub_err_i | input | 3 | Hub-side strobes, same bit order |
| hub_is_rcv_i | input | 1 | Hub side is acting as receiver |
| ram_err_i | input | 1 | Internal data RAM soft error strobe |
| live_addr_i | input | ADDR_W | Address on the pins |
| live_data_i | input | DATA_W | Data on the pins |
| live_be_i | input | BE_W | Byte enables on the pins |
| live_hdr_i | input | HDR_W | Header on the pins |
| ctx_addr_i | input | ADDR_W | Address of the originating request |
| ctx_data_i | input | DATA_W | Data of the originating request |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 16 | Bits to clear |
| status_o | output | 16 | Sticky status word |
| lock_o | output | 1 | A log is held |
| log_addr_o | output | ADDR_W | Captured address |
| log_data_o | output | DATA_W | Captured data |
| log_be_o | output | BE_W | Captured byte enables |
| log_hdr_o | output | HDR_W | Captured header |

## Verification
The hardest case to reach from the ports is a cycle in which several sources fire at once, with a low-priority kind on a high-priority side and a high-priority kind on a low-priority side. Only then do kind priority and side priority pull in different directions. The bench drives an abort on the PCI receiver, an address parity fault on the hub and a RAM error in the same cycle, and checks that the hub fault wins with the overflow bit set and live fields stored. A second case drives data parity on both PCI roles together. Sticky behaviour is reached by capturing an error, holding the functional reset low while further strobes arrive, and reading the log after release.

// File: rtl/ferr_pkg.sv
package ferr_pkg;

    localparam int STAT_W  = 16;
    localparam int OVF_BIT = 12;
    localparam int NUM_SRC = 10;
    localparam logic [STAT_W-1:0] STAT_VALID = 16'h1F3F;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_ABORT,
        KIND_APAR,
        KIND_DPAR,
        KIND_RAM
    } err_kind_e;

    // Status bit index visited at priority rank k (0 = highest).
    function automatic logic [3:0] prio_idx(input int k);
        logic [3:0] idx;
        case (k)
            0:       idx = 4'd1;
            1:       idx = 4'd4;
            2:       idx = 4'd9;
            3:       idx = 4'd2;
            4:       idx = 4'd5;
            5:       idx = 4'd10;
            6:       idx = 4'd0;
            7:       idx = 4'd3;
            8:       idx = 4'd8;
            default: idx = 4'd11;
        endcase
        return idx;
    endfunction

    function automatic err_kind_e kind_of_bit(input logic [3:0] idx);
        err_kind_e kd;
        case (idx)
            4'd0, 4'd3, 4'd8:  kd = KIND_ABORT;
            4'd1, 4'd4, 4'd9:  kd = KIND_APAR;
            4'd2, 4'd5, 4'd10: kd = KIND_DPAR;
            4'd11:             kd = KIND_RAM;
            default:           kd = KIND_NONE;
        endcase
        return kd;
    endfunction

endpackage

// File: rtl/ferr_arbiter.sv
module ferr_arbiter
    import ferr_pkg::*;
(
    input  logic [STAT_W-1:0] req_i,
    output logic [STAT_W-1:0] grant_o,
    output err_kind_e         kind_o,
    output logic              multi_o
);

    logic found;

    always_comb begin
        grant_o = '0;
        kind_o  = KIND_NONE;
        found   = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (!found && req_i[prio_idx(k)]) begin
                grant_o[prio_idx(k)] = 1'b1;
                kind_o               = kind_of_bit(prio_idx(k));
                found                = 1'b1;
            end
        end
        multi_o = ($countones(req_i) > 1);
    end

endmodule

// File: rtl/ferr_capture_sel.sv
module ferr_capture_sel
    import ferr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int HDR_W  = 8
) (
    input  err_kind_e         kind_i,
    input  logic [ADDR_W-1:0] live_addr_i,
    input  logic [DATA_W-1:0] live_data_i,
    input  logic [BE_W-1:0]   live_be_i,
    input  logic [HDR_W-1:0]  live_hdr_i,
    input  logic [ADDR_W-1:0] ctx_addr_i,
    input  logic [DATA_W-1:0] ctx_data_i,
    output logic [ADDR_W-1:0] sel_addr_o,
    output logic [DATA_W-1:0] sel_data_o,
    output logic [BE_W-1:0]   sel_be_o,
    output logic [HDR_W-1:0]  sel_hdr_o
);

    always_comb begin
        sel_addr_o = ctx_addr_i;
        sel_data_o = ctx_data_i;
        sel_be_o   = '0;
        sel_hdr_o  = '0;
        unique case (kind_i)
            KIND_APAR: begin
                sel_addr_o = live_addr_i;
                sel_data_o = live_data_i;
                sel_be_o   = live_be_i;
                sel_hdr_o  = live_hdr_i;
            end
            KIND_DPAR: begin
                sel_data_o = live_data_i;
                sel_be_o   = live_be_i;
            end
            KIND_ABORT, KIND_RAM, KIND_NONE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/first_err_log.sv
module first_err_log
    import ferr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int HDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_n,
    input  logic [2:0]        pci_rcv_err_i,
    input  logic [2:0]        pci_gen_err_i,
    input  logic [2:0]        hub_err_i,
    input  logic              hub_is_rcv_i,
    input  logic              ram_err_i,
    input  logic [ADDR_W-1:0] live_addr_i,
    input  logic [DATA_W-1:0] live_data_i,
    input  logic [BE_W-1:0]   live_be_i,
    input  logic [HDR_W-1:0]  live_hdr_i,
    input  logic [ADDR_W-1:0] ctx_addr_i,
    input  logic [DATA_W-1:0] ctx_data_i,
    input  logic              clr_we_i,
    input  logic [15:0]       clr_mask_i,
    output logic [15:0]       status_o,
    output logic              lock_o,
    output logic [ADDR_W-1:0] log_addr_o,
    output logic [DATA_W-1:0] log_data_o,
    output logic [BE_W-1:0]   log_be_o,
    output logic [HDR_W-1:0]  log_hdr_o
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              lock;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [HDR_W-1:0]  hdr;
    } state_t;

    state_t st_q, st_d;

    logic [STAT_W-1:0] req;
    logic [STAT_W-1:0] grant;
    err_kind_e         kind;
    logic              multi;
    logic              take;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic [BE_W-1:0]   sel_be;
    logic [HDR_W-1:0]  sel_hdr;

    // Map strobes onto their status positions; hub counts only as receiver.
    always_comb begin
        req        = '0;
        req[2:0]   = pci_rcv_err_i;
        req[5:3]   = pci_gen_err_i;
        req[10:8]  = hub_is_rcv_i ? hub_err_i : 3'b000;
        req[11]    = ram_err_i;
    end

    ferr_arbiter i_arb (
        .req_i   (req),
        .grant_o (grant),
        .kind_o  (kind),
        .multi_o (multi)
    );

    ferr_capture_sel #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .HDR_W  (HDR_W)
    ) i_sel (
        .kind_i      (kind),
        .live_addr_i (live_addr_i),
        .live_data_i (live_data_i),
        .live_be_i   (live_be_i),
        .live_hdr_i  (live_hdr_i),
        .ctx_addr_i  (ctx_addr_i),
        .ctx_data_i  (ctx_data_i),
        .sel_addr_o  (sel_addr),
        .sel_data_o  (sel_data),
        .sel_be_o    (sel_be),
        .sel_hdr_o   (sel_hdr)
    );

    always_comb begin
        st_d = st_q;
        take = rst_n && !st_q.lock && (|req);

        if (clr_we_i) begin
            st_d.status = st_q.status & ~clr_mask_i;
        end

        if (take) begin
            st_d.status          = grant & STAT_VALID;
            st_d.status[OVF_BIT] = multi;
            st_d.lock            = 1'b1;
            st_d.addr            = sel_addr;
            st_d.data            = sel_data;
            st_d.be              = sel_be;
            st_d.hdr             = sel_hdr;
        end else if (st_q.lock && (st_d.status == '0)) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o   = st_q.status;
    assign lock_o     = st_q.lock;
    assign log_addr_o = st_q.addr;
    assign log_data_o = st_q.data;
    assign log_be_o   = st_q.be;
    assign log_hdr_o  = st_q.hdr;

endmodule

// File: rtl/ferr_log_chk.sv
module ferr_log_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int HDR_W  = 8
) (
    input logic              clk,
    input logic              rst_por_n,
    input logic              rst_n,
    input logic [2:0]        pci_rcv_err_i,
    input logic [2:0]        pci_gen_err_i,
    input logic [2:0]        hub_err_i,
    input logic              hub_is_rcv_i,
    input logic              ram_err_i,
    input logic              clr_we_i,
    input logic [15:0]       status_o,
    input logic              lock_o,
    input logic [ADDR_W-1:0] log_addr_o,
    input logic [DATA_W-1:0] log_data_o,
    input logic [BE_W-1:0]   log_be_o,
    input logic [HDR_W-1:0]  log_hdr_o
);

    logic any_req;
    logic hub_only_tx;

    assign any_req = (|pci_rcv_err_i) || (|pci_gen_err_i) ||
                     (hub_is_rcv_i && (|hub_err_i)) || ram_err_i;
    assign hub_only_tx = !hub_is_rcv_i && (|hub_err_i) && !(|pci_rcv_err_i) &&
                         !(|pci_gen_err_i) && !ram_err_i;

    // R1
    capture_locks_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (rst_n && !lock_o && any_req) |=> lock_o);

    // R1
    frozen_log_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        lock_o |=> ($stable(log_addr_o) && $stable(log_data_o) &&
                    $stable(log_be_o) && $stable(log_hdr_o)));

    // R9
    lock_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        lock_o == (status_o != 16'h0000));

    // R6
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        $countones(status_o & 16'h0F3F) <= 1);

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (status_o & 16'hE0C0) == 16'h0000);

    // R10
    func_reset_keep_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!rst_n && !clr_we_i) |=> ($stable(status_o) && $stable(lock_o)));

    // R7
    hub_tx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!lock_o && hub_only_tx) |=> !lock_o);

endmodule

bind first_err_log ferr_log_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W),
    .HDR_W  (HDR_W)
) i_chk (
    .clk           (clk),
    .rst_por_n     (rst_por_n),
    .rst_n         (rst_n),
    .pci_rcv_err_i (pci_rcv_err_i),
    .pci_gen_err_i (pci_gen_err_i),
    .hub_err_i     (hub_err_i),
    .hub_is_rcv_i  (hub_is_rcv_i),
    .ram_err_i     (ram_err_i),
    .clr_we_i      (clr_we_i),
    .status_o      (status_o),
    .lock_o        (lock_o),
    .log_addr_o    (log_addr_o),
    .log_data_o    (log_data_o),
    .log_be_o      (log_be_o),
    .log_hdr_o     (log_hdr_o)
);

// File: tb/test_first_err_log.sv
`timescale 1ns/1ps
module test_first_err_log;

    logic        clk = 1'b0;
    logic        rst_por_n, rst_n;
    logic [2:0]  pci_rcv, pci_gen, hub;
    logic        hub_rx, ram;
    logic [31:0] live_addr, live_data, ctx_addr, ctx_data;
    logic [3:0]  live_be;
    logic [7:0]  live_hdr;
    logic        clr_we;
    logic [15:0] clr_mask;
    logic [15:0] status;
    logic        lock;
    logic [31:0] log_addr, log_data;
    logic [3:0]  log_be;
    logic [7:0]  log_hdr;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    first_err_log i_first_err_log (
        .clk(clk), .rst_por_n(rst_por_n), .rst_n(rst_n),
        .pci_rcv_err_i(pci_rcv), .pci_gen_err_i(pci_gen), .hub_err_i(hub),
        .hub_is_rcv_i(hub_rx), .ram_err_i(ram),
        .live_addr_i(live_addr), .live_data_i(live_data),
        .live_be_i(live_be), .live_hdr_i(live_hdr),
        .ctx_addr_i(ctx_addr), .ctx_data_i(ctx_data),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .status_o(status), .lock_o(lock),
        .log_addr_o(log_addr), .log_data_o(log_data),
        .log_be_o(log_be), .log_hdr_o(log_hdr)
    );

    localparam logic [31:0] LA = 32'h0000_7770, LD = 32'h1357_9BDF;
    localparam logic [31:0] CA = 32'hC0DE_1000, CD = 32'hFEED_0042;
    localparam logic [3:0]  LB = 4'hB;
    localparam logic [7:0]  LH = 8'h5A;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input logic [15:0] st, input logic lk,
                           input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] b, input logic [7:0] h);
        chk({tag, " status"}, 64'(status), 64'(st));
        chk({tag, " lock"},   64'(lock),   64'(lk));
        chk({tag, " addr"},   64'(log_addr), 64'(a));
        chk({tag, " data"},   64'(log_data), 64'(d));
        chk({tag, " be"},     64'(log_be),   64'(b));
        chk({tag, " hdr"},    64'(log_hdr),  64'(h));
    endtask

    // Drive one strobe cycle; returns at the negedge after the capturing edge.
    task automatic strobe(input logic [2:0] pr, input logic [2:0] pg, input logic [2:0] hb,
                          input logic hrx, input logic rm);
        @(negedge clk);
        pci_rcv = pr; pci_gen = pg; hub = hb; hub_rx = hrx; ram = rm;
        @(negedge clk);
        pci_rcv = '0; pci_gen = '0; hub = '0; ram = 1'b0;
    endtask

    task automatic clear(input logic [15:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset_state();
        chk_log("R11 por", 16'h0, 1'b0, 32'h0, 32'h0, 4'h0, 8'h0);
    endtask

    task automatic t_abort_split();
        strobe(3'b001, 3'b000, 3'b000, 1'b1, 1'b0);
        chk_log("R2/R6 abort ctx", 16'h0001, 1'b1, CA, CD, 4'h0, 8'h0);
    endtask

    task automatic t_locked_ignore();
        live_addr = 32'hAAAA_0000;
        strobe(3'b010, 3'b111, 3'b111, 1'b1, 1'b1);
        chk_log("R1 locked", 16'h0001, 1'b1, CA, CD, 4'h0, 8'h0);
        live_addr = LA;
    endtask

    task automatic t_partial_clear();
        clear(16'h0002);
        chk_log("R9 partial", 16'h0001, 1'b1, CA, CD, 4'h0, 8'h0);
        clear(16'h0001);
        chk("R9 release status", 64'(status), 64'h0);
        chk("R9 release lock", 64'(lock), 64'h0);
    endtask

    task automatic t_apar_gen();
        strobe(3'b000, 3'b010, 3'b000, 1'b1, 1'b0);
        chk_log("R3 apar live", 16'h0010, 1'b1, LA, LD, LB, LH);
        clear(16'hFFFF);
        chk("R12 reserved after full write", 64'(status), 64'h0);
    endtask

    task automatic t_dpar_hub();
        strobe(3'b000, 3'b000, 3'b100, 1'b1, 1'b0);
        chk_log("R4/R7 hub dpar", 16'h0400, 1'b1, CA, LD, LB, 8'h0);
        clear(16'h0400);
    endtask

    task automatic t_hub_tx_ignored();
        strobe(3'b000, 3'b000, 3'b111, 1'b0, 1'b0);
        chk("R7 hub tx status", 64'(status), 64'h0);
        chk("R7 hub tx lock", 64'(lock), 64'h0);
        hub_rx = 1'b1;
    endtask

    task automatic t_ram();
        strobe(3'b000, 3'b000, 3'b000, 1'b1, 1'b1);
        chk_log("R5 ram", 16'h0800, 1'b1, CA, CD, 4'h0, 8'h0);
        clear(16'h0800);
    endtask

    task automatic t_multi_kind();
        strobe(3'b001, 3'b000, 3'b010, 1'b1, 1'b1);
        chk_log("R8 kind prio", 16'h1200, 1'b1, LA, LD, LB, LH);
        clear(16'h0200);
        chk("R9 ovf keeps lock", 64'(lock), 64'h1);
        clear(16'h1000);
    endtask

    task automatic t_multi_side();
        strobe(3'b100, 3'b100, 3'b000, 1'b1, 1'b0);
        chk_log("R8 side prio", 16'h1004, 1'b1, CA, LD, LB, 8'h0);
        clear(16'h1004);
    endtask

    task automatic t_func_reset();
        strobe(3'b000, 3'b001, 3'b000, 1'b1, 1'b0);
        chk("R6 gen abort", 64'(status), 64'h0008);
        @(negedge clk);
        rst_n = 1'b0;
        strobe(3'b010, 3'b000, 3'b000, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_log("R10 kept", 16'h0008, 1'b1, CA, CD, 4'h0, 8'h0);
        clear(16'h0008);
        @(negedge clk);
        rst_n = 1'b0;
        strobe(3'b010, 3'b000, 3'b000, 1'b1, 1'b0);
        chk("R10 strobe ignored", 64'(lock), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_por();
        strobe(3'b010, 3'b000, 3'b000, 1'b1, 1'b0);
        chk("R11 pre", 64'(status), 64'h0002);
        @(negedge clk);
        rst_por_n = 1'b0;
        @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);
        chk_log("R11 cleared", 16'h0, 1'b0, 32'h0, 32'h0, 4'h0, 8'h0);
    endtask

    initial begin
        rst_por_n = 1'b0; rst_n = 1'b0;
        pci_rcv = '0; pci_gen = '0; hub = '0; hub_rx = 1'b1; ram = 1'b0;
        live_addr = LA; live_data = LD; live_be = LB; live_hdr = LH;
        ctx_addr = CA; ctx_data = CD;
        clr_we = 1'b0; clr_mask = '0;
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_abort_split();
        t_locked_ignore();
        t_partial_clear();
        t_apar_gen();
        t_dpar_hub();
        t_hub_tx_ignored();
        t_ram();
        t_multi_kind();
        t_multi_side();
        t_func_reset();
        t_por();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule